// File: doc/BRIEF.md
# DDR2 Precharge Spacing Guard

This block watches the command pins of an eight-bank DDR2 memory and judges each activate, read and precharge as it appears on the bus. Each command is sampled on a rising clock edge. For every bank it keeps the open or closed state and three saturating cycle counters: cycles since the last accepted activate, since the last accepted read, and since the last accepted precharge. From these it decides whether the command respects the spacing rules for closing and reopening a row.

One cycle after a command is sampled, the guard reports the result. An accept pulse means the command was legal. A violation pulse means it was not, and a code names the broken rule. Only an accepted command updates bank state. Additive latency, burst length, a high-frequency flag and the minimum active time, precharge time and row cycle time are configuration inputs. These inputs must be held steady while traffic runs. Writes, refresh, mode-register loads, deselects and no-ops are not judged.

Top module: `ddr2_pre_guard`

## Requirements
- R1: The pin patterns are decoded as follows, with all pins active low: precharge is cs_n=0, ras_n=0, cas_n=1, we_n=0. Activate is cs_n=0, ras_n=0, cas_n=1, we_n=1. Read is cs_n=0, ras_n=1, cas_n=0, we_n=1. Any other pattern, including a write (0,1,0,0), a refresh (0,0,0,1) or cs_n=1, produces neither an accept pulse nor a violation pulse.
- R2: A precharge with a10=1 targets every bank and ignores ba. When it is legal, all open banks are closed. Banks that were already closed are left untouched, so their precharge-time counters do not restart.
- R3: A precharge with a10=0 targets only the bank numbered by ba, read as an unsigned value (ba=5 is bank 5). Activate and read use the same bank numbering.
- R4: With cfg_hifreq=0, a precharge is a violation (code 1) if any targeted open bank had a read fewer than AL + BL/2 cycles earlier. BL/2 is 4 when cfg_bl8=1 and 2 when cfg_bl8=0.
- R5: With cfg_hifreq=1, the read-to-precharge minimum of R4 becomes AL + BL/2 + 1 cycles.
- R6: A precharge is a violation (code 2) if any targeted open bank was activated fewer than cfg_tras cycles earlier.
- R7: An activate is a violation (code 3) if its bank was precharged fewer than cfg_trp cycles earlier.
- R8: An activate is a violation (code 4) if its bank was activated fewer than cfg_trc cycles earlier.
- R9: An activate to an open bank is a violation (code 5). A read to a closed bank is a violation (code 6). A legal activate opens its bank.
- R10: Reset closes all banks, clears both pulses and sets every counter to its satisfied limit, so that an activate right after reset is legal.
- R11: A command that is a violation, or a pattern that is not judged, leaves bank_open unchanged.
- R12: When several rules fail at once, one code is reported by priority. For a precharge, code 1 wins over code 2. For an activate, the order is code 5, then 3, then 4. Result pulses appear one cycle after the command edge, with viol_code=0 whenever viol=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | All-banks select for precharge |
| ba | input | 3 | Bank number |
| cfg_al | input | 3 | Additive latency in cycles |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_hifreq | input | 1 | High-frequency mode, adds one cycle to read-to-precharge |
| cfg_tras | input | 6 | Minimum activate-to-precharge cycles |
| cfg_trp | input | 6 | Minimum precharge-to-activate cycles |
| cfg_trc | input | 6 | Minimum activate-to-activate cycles, same bank |
| chk_ok | output | 1 | One-cycle pulse: judged command was legal |
| viol | output | 1 | One-cycle pulse: judged command broke a rule |
| viol_code | output | 3 | Rule broken (1..6), 0 when no violation |
| bank_open | output | 8 | Open state of each bank |

## Verification
Two rules can fail on the same command. The first such case is an all-banks precharge issued while one open bank is still inside its read-to-precharge window and another open bank is still inside its minimum active time. The second is an activate issued just after a precharge, which also falls inside the row cycle window. The bench provokes both by sequencing commands a known number of cycles apart. It expects the higher-priority code and expects bank_open to stay unchanged. Each boundary is also probed one cycle short of the limit and exactly at the limit, and the scoreboard compares every cycle's result pulses and bank state.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    VC_NONE      = 3'd0,
    VC_RTP       = 3'd1,
    VC_RAS       = 3'd2,
    VC_RP        = 3'd3,
    VC_RC        = 3'd4,
    VC_ACT_OPEN  = 3'd5,
    VC_RD_CLOSED = 3'd6
  } viol_e;

  typedef struct packed {
    logic act;
    logic rd;
    logic pre;
  } cmd_s;
endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_s cmd
);
  always_comb begin
    cmd.act = !cs_n && !ras_n &&  cas_n &&  we_n;
    cmd.rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
    cmd.pre = !cs_n && !ras_n &&  cas_n && !we_n;
  end
endmodule

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_pre,
  input  logic [CNT_W-1:0] rtp_need,
  input  logic [CNT_W-1:0] tras,
  input  logic [CNT_W-1:0] trp,
  input  logic [CNT_W-1:0] trc,
  output logic             is_open,
  output logic             rtp_ok,
  output logic             ras_ok,
  output logic             rp_ok,
  output logic             rc_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             open_q, open_n;
  logic [CNT_W-1:0] cnt_act_q, cnt_act_n;
  logic [CNT_W-1:0] cnt_rd_q,  cnt_rd_n;
  logic [CNT_W-1:0] cnt_pre_q, cnt_pre_n;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  always_comb begin
    open_n    = open_q;
    cnt_act_n = sat_inc(cnt_act_q);
    cnt_rd_n  = sat_inc(cnt_rd_q);
    cnt_pre_n = sat_inc(cnt_pre_q);
    if (do_act) begin
      open_n    = 1'b1;
      cnt_act_n = CNT_ONE;
    end
    if (do_rd) begin
      cnt_rd_n = CNT_ONE;
    end
    if (do_pre) begin
      open_n    = 1'b0;
      cnt_pre_n = CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt_act_q <= CNT_MAX;
      cnt_rd_q  <= CNT_MAX;
      cnt_pre_q <= CNT_MAX;
    end else begin
      open_q    <= open_n;
      cnt_act_q <= cnt_act_n;
      cnt_rd_q  <= cnt_rd_n;
      cnt_pre_q <= cnt_pre_n;
    end
  end

  assign is_open = open_q;
  assign rtp_ok  = (cnt_rd_q  >= rtp_need);
  assign ras_ok  = (cnt_act_q >= tras);
  assign rp_ok   = (cnt_pre_q >= trp);
  assign rc_ok   = (cnt_act_q >= trc);

  // R10: counters start satisfied and saturate, never wrapping to zero
  a_r10_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_act_q != '0) && (cnt_rd_q != '0) && (cnt_pre_q != '0));

  // R9: the rule checker only grants an activate to a closed bank
  a_r9_act_closed_only: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> !open_q);

  // R7: an accepted precharge restarts the precharge timer
  a_r7_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |=> (cnt_pre_q == CNT_ONE) && !open_q);
endmodule

// File: rtl/ddr2_rule_check.sv
module ddr2_rule_check
  import ddr2_guard_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int BA_W = $clog2(NBANK)
) (
  input  cmd_s              cmd,
  input  logic              a10,
  input  logic [BA_W-1:0]   ba,
  input  logic [NBANK-1:0]  open_v,
  input  logic [NBANK-1:0]  rtp_ok_v,
  input  logic [NBANK-1:0]  ras_ok_v,
  input  logic [NBANK-1:0]  rp_ok_v,
  input  logic [NBANK-1:0]  rc_ok_v,
  output viol_e             code,
  output logic              legal,
  output logic [NBANK-1:0]  do_act_v,
  output logic [NBANK-1:0]  do_rd_v,
  output logic [NBANK-1:0]  do_pre_v
);
  logic [NBANK-1:0] sel, tgt;
  logic             rtp_bad, ras_bad;

  assign sel     = NBANK'(1) << ba;
  assign tgt     = a10 ? '1 : sel;
  assign rtp_bad = |(tgt & open_v & ~rtp_ok_v);
  assign ras_bad = |(tgt & open_v & ~ras_ok_v);

  always_comb begin
    code = VC_NONE;
    if (cmd.pre) begin
      if (rtp_bad)      code = VC_RTP;
      else if (ras_bad) code = VC_RAS;
    end else if (cmd.act) begin
      if (open_v[ba])        code = VC_ACT_OPEN;
      else if (!rp_ok_v[ba]) code = VC_RP;
      else if (!rc_ok_v[ba]) code = VC_RC;
    end else if (cmd.rd) begin
      if (!open_v[ba])       code = VC_RD_CLOSED;
    end
  end

  assign legal    = (code == VC_NONE);
  assign do_pre_v = (cmd.pre && legal) ? (tgt & open_v) : '0;
  assign do_act_v = (cmd.act && legal) ? sel : '0;
  assign do_rd_v  = (cmd.rd  && legal) ? sel : '0;
endmodule

// File: rtl/ddr2_pre_guard.sv
module ddr2_pre_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int CNT_W = 6,
  parameter int AL_W  = 3,
  localparam int BA_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              a10,
  input  logic [BA_W-1:0]   ba,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic              cfg_bl8,
  input  logic              cfg_hifreq,
  input  logic [CNT_W-1:0]  cfg_tras,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_trc,
  output logic              chk_ok,
  output logic              viol,
  output logic [CODE_W-1:0] viol_code,
  output logic [NBANK-1:0]  bank_open
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s0, rst_s1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_n_s = rst_s1;

  cmd_s             cmd;
  viol_e            code;
  logic             legal, judged;
  logic [NBANK-1:0] rtp_ok_v, ras_ok_v, rp_ok_v, rc_ok_v;
  logic [NBANK-1:0] do_act_v, do_rd_v, do_pre_v;
  logic [CNT_W-1:0] rtp_need;

  assign rtp_need = CNT_W'(cfg_al) + (cfg_bl8 ? CNT_W'(4) : CNT_W'(2))
                  + CNT_W'(cfg_hifreq);

  ddr2_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  ddr2_rule_check #(.NBANK(NBANK)) u_rule (
    .cmd     (cmd),      .a10     (a10),      .ba      (ba),
    .open_v  (bank_open),.rtp_ok_v(rtp_ok_v), .ras_ok_v(ras_ok_v),
    .rp_ok_v (rp_ok_v),  .rc_ok_v (rc_ok_v),  .code    (code),
    .legal   (legal),    .do_act_v(do_act_v), .do_rd_v (do_rd_v),
    .do_pre_v(do_pre_v)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr2_bank_timer #(.CNT_W(CNT_W)) u_bank (
      .clk     (clk),         .rst_n   (rst_n_s),
      .do_act  (do_act_v[b]), .do_rd   (do_rd_v[b]), .do_pre(do_pre_v[b]),
      .rtp_need(rtp_need),    .tras    (cfg_tras),
      .trp     (cfg_trp),     .trc     (cfg_trc),
      .is_open (bank_open[b]),.rtp_ok  (rtp_ok_v[b]),
      .ras_ok  (ras_ok_v[b]), .rp_ok   (rp_ok_v[b]), .rc_ok(rc_ok_v[b])
    );
  end

  // result registers
  logic              ok_q, ok_n, viol_q, viol_n;
  logic [CODE_W-1:0] code_q, code_n;

  assign judged = cmd.act || cmd.rd || cmd.pre;

  always_comb begin
    ok_n   = judged && legal;
    viol_n = judged && !legal;
    code_n = viol_n ? code : VC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ok_q   <= 1'b0;
      viol_q <= 1'b0;
      code_q <= VC_NONE;
    end else begin
      ok_q   <= ok_n;
      viol_q <= viol_n;
      code_q <= code_n;
    end
  end

  assign chk_ok    = ok_q;
  assign viol      = viol_q;
  assign viol_code = code_q;

  logic [NBANK-1:0] sel_dbg;
  assign sel_dbg = NBANK'(1) << ba;

  // R2: legal all-banks precharge leaves every bank closed
  a_r2_all_close: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd.pre && a10 && legal) |=> (bank_open == '0));

  // R3: legal single-bank precharge closes only the addressed bank
  a_r3_one_close: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd.pre && !a10 && legal) |=> (bank_open == ($past(bank_open) & ~$past(sel_dbg))));

  // R9: legal activate opens exactly its bank
  a_r9_act_opens: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd.act && legal) |=> (bank_open == ($past(bank_open) | $past(sel_dbg))));

  // R11: rejected or unjudged commands leave bank state alone
  a_r11_hold_state: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(judged && legal)) |=> $stable(bank_open));

  // R12: at most one result pulse, and a code exactly when violating
  a_r12_pulse_code: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({chk_ok, viol}) && (viol == (viol_code != '0)));
endmodule

// File: tb/tb_ddr2_pre_guard.sv
module tb_ddr2_pre_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [2:0] ba = '0;
  logic [2:0] cfg_al = 3'd0;
  logic       cfg_bl8 = 1'b0, cfg_hifreq = 1'b0;
  logic [5:0] cfg_tras = 6'd6, cfg_trp = 6'd3, cfg_trc = 6'd12;
  logic       chk_ok, viol;
  logic [2:0] viol_code;
  logic [7:0] bank_open;

  ddr2_pre_guard dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .ba(ba), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .cfg_hifreq(cfg_hifreq), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .chk_ok(chk_ok), .viol(viol), .viol_code(viol_code),
    .bank_open(bank_open)
  );

  always #5 clk = ~clk;

  typedef enum {C_NOP, C_ACT, C_RD, C_PRE, C_WR, C_DES, C_REF} bcmd_e;
  localparam int XN = -1; // no pulse expected; 0 = accept; 1..6 = code

  typedef struct {
    int         exp;
    logic [7:0] open;
    string      tag;
  } item_t;

  item_t      q[$];
  logic [7:0] m_open = '0;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  task automatic chk(bit good, string tag, int act, int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(bcmd_e c, logic a, logic [2:0] b, int exp, string tag);
    item_t it;
    @(negedge clk);
    a10 = a; ba = b;
    case (c)
      C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      C_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1010;
      C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
    if (exp == 0) begin
      if (c == C_ACT) m_open[b] = 1'b1;
      if (c == C_PRE) m_open = a ? 8'h00 : (m_open & ~(8'h01 << b));
    end
    it.exp = exp; it.open = m_open; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic nop(int n, string tag);
    for (int i = 0; i < n; i++) issue(C_NOP, 1'b0, 3'd0, XN, tag);
  endtask

  // monitor: results registered on the edge, sampled 2 ns later
  always @(posedge clk) begin
    item_t it;
    int    got;
    #2;
    if (q.size() > 0) begin
      it  = q.pop_front();
      got = viol ? int'(viol_code) : (chk_ok ? 0 : XN);
      chk(got == it.exp, {it.tag, " result"}, got, it.exp);
      chk(bank_open == it.open, {it.tag, " bank_open"}, int'(bank_open), int'(it.open));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(bank_open == 8'h00, "R10 reset bank_open", int'(bank_open), 0);
    chk(!chk_ok && !viol, "R10 reset pulses", int'({chk_ok, viol}), 0);

    nop(1, "R10 idle");
    issue(C_ACT, 0, 3'd0, 0, "R10 act after reset");
    issue(C_PRE, 0, 3'd0, 2, "R6 ras short");
    issue(C_RD,  0, 3'd0, 0, "R9 read open bank");
    issue(C_PRE, 0, 3'd0, 1, "R12 rtp before ras");
    nop(2, "R6 wait");
    issue(C_PRE, 0, 3'd0, 0, "R6 ras met");
    issue(C_ACT, 0, 3'd0, 3, "R12 rp before rc");
    issue(C_ACT, 0, 3'd0, 3, "R7 rp short");
    issue(C_ACT, 0, 3'd0, 4, "R8 rc short");
    nop(2, "R8 wait");
    issue(C_ACT, 0, 3'd0, 0, "R8 rc met");
    issue(C_ACT, 0, 3'd0, 5, "R9 act open bank");
    issue(C_RD,  0, 3'd3, 6, "R9 read closed bank");
    issue(C_WR,  1, 3'd0, XN, "R1 write ignored");
    issue(C_DES, 1, 3'd0, XN, "R1 deselect ignored");
    issue(C_REF, 0, 3'd0, XN, "R11 refresh ignored");
    issue(C_RD,  0, 3'd0, 0, "R4 read");
    issue(C_PRE, 0, 3'd0, 1, "R4 one short");
    issue(C_PRE, 0, 3'd0, 0, "R4 exact");
    nop(1, "R5 cfg");
    cfg_al = 3'd1; cfg_bl8 = 1'b1; cfg_hifreq = 1'b1; // need 1+4+1=6
    issue(C_ACT, 0, 3'd2, 0, "R5 open");
    issue(C_RD,  0, 3'd2, 0, "R5 read");
    nop(4, "R5 wait");
    issue(C_PRE, 0, 3'd2, 1, "R5 one short");
    issue(C_PRE, 0, 3'd2, 0, "R5 exact");
    issue(C_ACT, 0, 3'd4, 0, "R2 open b4");
    issue(C_ACT, 0, 3'd6, 0, "R2 open b6");
    issue(C_RD,  0, 3'd6, 0, "R2 read b6");
    issue(C_PRE, 1, 3'd0, 1, "R12 all-bank rtp and ras");
    nop(4, "R2 wait");
    issue(C_PRE, 1, 3'd3, 0, "R2 all close");
    issue(C_PRE, 1, 3'd0, 0, "R2 idle precharge");
    issue(C_ACT, 0, 3'd1, 0, "R2 idle bank not restarted");
    issue(C_ACT, 0, 3'd5, 0, "R3 open b5");
    nop(5, "R3 wait");
    issue(C_PRE, 0, 3'd5, 0, "R3 single close");
    issue(C_ACT, 0, 3'd5, 3, "R7 after single");
    issue(C_RD,  0, 3'd1, 0, "R3 b1 still open");
    nop(2, "flush");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule